// File: doc/BRIEF.md
# UART Modem Control, Line Status and Flow Control

This block holds the modem-control settings of a UART and produces the modem-status view of it. It drives the active-low handshake and general-purpose outputs (RTS, DTR, OUT1, OUT2). It samples the four active-low line inputs (CTS, DSR, RI, DCD) through a synchroniser. It keeps sticky change flags that are cleared by a status read. While any flag is set, it raises an interrupt request.

A loopback mode routes the control settings back to the status inputs for self-test. In this mode the handshake outputs are parked inactive, and the serial framer is told to hold its transmit line high. Automatic flow control uses the receive FIFO fill level and the trigger threshold to throttle RTS. It also gates the start of each transmitted character on CTS. The serial framer and the FIFOs are outside this block. The block only sees the FIFO level, the trigger value and a one-cycle start-bit pulse from the receiver.

Top module: `uart_modem_ctl`

## Requirements
- R1: After synchronous reset, rts_n, dtr_n, out1_n and out2_n are 1, stat_q is 0x00, ms_irq and loop_active are 0 and tx_permit is 1.
- R2: Control word bits are: bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 loopback, bit5 auto-flow. Outside loopback, dtr_n, out1_n and out2_n are the inverse of bits 0, 2 and 3. With auto-flow clear, rts_n is the inverse of bit1.
- R3: Outside loopback, stat_q[4] is CTS, stat_q[5] is DSR, stat_q[6] is RI and stat_q[7] is DCD. Each is the inverse of its active-low pin after synchronisation.
- R4: Change flags are stat_q[0] for CTS, stat_q[1] for DSR, stat_q[2] for RI and stat_q[3] for DCD. Bits 0, 1 and 3 set on any change of their line. Bit 2 sets only when RI goes from inactive to active (ri_n from 1 to 0).
- R5: A cycle with stat_rd high clears all four change flags. A flag whose event lands in that same cycle stays set. Without a read, set flags remain set.
- R6: ms_irq is 1 exactly when at least one change flag is set.
- R7: In loopback, all four handshake outputs are 1 and loop_active is 1. The external pins are ignored, and status reads CTS from the RTS bit, DSR from the DTR bit, RI from OUT1 and DCD from OUT2.
- R8: In loopback, a stat_wr with stat_wdata sets every change flag whose data bit is 1 and leaves the others unchanged. Outside loopback, stat_wr has no effect.
- R9: With auto-flow and RTS both set, rts_n is 0 while rx_level < rx_trig. rts_n goes to 1 when rx_start pulses while rx_level >= rx_trig, and returns to 0 once rx_level < rx_trig. With the RTS bit clear, rts_n is 1 regardless of auto-flow.
- R10: tx_permit is 1 when auto-flow is clear. When auto-flow is set, tx_permit equals the CTS status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Load control word |
| ctrl_wdata | input | 6 | Control word (DTR, RTS, OUT1, OUT2, loopback, auto-flow) |
| stat_rd | input | 1 | Status read strobe, clears change flags |
| stat_wr | input | 1 | Change-flag set strobe (loopback only) |
| stat_wdata | input | 4 | Change flags to set |
| stat_q | output | 8 | Line states [7:4] and change flags [3:0] |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring-indicator pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive trigger threshold |
| rx_start | input | 1 | One-cycle start-bit-seen pulse |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| loop_active | output | 1 | Loopback on; framer holds TX high |
| tx_permit | output | 1 | Framer may start a new character |
| ms_irq | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that rst is held high from time zero through the first clock edge. They also assume that stat_rd and stat_wr are single-cycle strobes aligned to the clock. The bench drives every input on the falling edge, so each change is seen whole at one rising edge. It changes the line pins only after the previous change has fully passed through the synchroniser. For this reason each flag check can attribute a flag to exactly one pin transition. The one deliberate exception is the read-collision test, which times a read to the edge where an event arrives.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
  typedef struct packed {
    logic afc;
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mctl_t;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mline_t;

  localparam int unsigned MCTL_W  = $bits(mctl_t);
  localparam int unsigned MLINE_W = $bits(mline_t);
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= {WIDTH{RST_VAL}};
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= {WIDTH{RST_VAL}};
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/modem_status.sv
module modem_status
  import uart_modem_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         loop_en,
  input  logic         lb_rts,
  input  logic         lb_dtr,
  input  logic         lb_out1,
  input  logic         lb_out2,
  input  mline_t       pins_n,
  input  logic         rd_clr,
  input  logic         wr_set,
  input  mline_t       wr_flags,
  output mline_t       line_q,
  output mline_t       flag_q,
  output logic         irq_q
);
  mline_t eff, evt, flag_n;

  always_comb begin
    if (loop_en) begin
      eff.cts = lb_rts;
      eff.dsr = lb_dtr;
      eff.ri  = lb_out1;
      eff.dcd = lb_out2;
    end else begin
      eff = ~pins_n;
    end
  end

  always_comb begin
    evt.cts = eff.cts ^ line_q.cts;
    evt.dsr = eff.dsr ^ line_q.dsr;
    evt.dcd = eff.dcd ^ line_q.dcd;
    evt.ri  = eff.ri & ~line_q.ri;
  end

  always_comb begin
    flag_n = rd_clr ? '0 : flag_q;
    flag_n = flag_n | evt;
    if (loop_en && wr_set) flag_n = flag_n | wr_flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      line_q <= eff;
      flag_q <= flag_n;
      irq_q  <= |flag_n;
    end
  end
endmodule

// File: rtl/modem_flow.sv
module modem_flow #(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loop_en,
  input  logic             afc_en,
  input  logic             rts_bit,
  input  logic             dtr_bit,
  input  logic             out1_bit,
  input  logic             out2_bit,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] trig,
  input  logic             start_seen,
  input  logic             cts_now,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             out1_n,
  output logic             out2_n,
  output logic             loop_q,
  output logic             permit_q
);
  logic auto_on, below, throttle, rts_act;

  assign auto_on = afc_en & rts_bit;
  assign below   = level < trig;
  assign rts_act = rts_bit & ~(auto_on & throttle);

  always_ff @(posedge clk) begin
    if (rst)                        throttle <= 1'b0;
    else if (!auto_on || below)     throttle <= 1'b0;
    else if (start_seen)            throttle <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n    <= 1'b1;
      dtr_n    <= 1'b1;
      out1_n   <= 1'b1;
      out2_n   <= 1'b1;
      loop_q   <= 1'b0;
      permit_q <= 1'b1;
    end else begin
      rts_n    <= loop_en | ~rts_act;
      dtr_n    <= loop_en | ~dtr_bit;
      out1_n   <= loop_en | ~out1_bit;
      out2_n   <= loop_en | ~out2_bit;
      loop_q   <= loop_en;
      permit_q <= ~afc_en | cts_now;
    end
  end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_modem_pkg::*;
#(
  parameter int unsigned LVL_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [5:0]       ctrl_wdata,
  input  logic             stat_rd,
  input  logic             stat_wr,
  input  logic [3:0]       stat_wdata,
  output logic [7:0]       stat_q,
  input  logic             cts_n,
  input  logic             dsr_n,
  input  logic             ri_n,
  input  logic             dcd_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             rx_start,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             out1_n,
  output logic             out2_n,
  output logic             loop_active,
  output logic             tx_permit,
  output logic             ms_irq
);
  mctl_t  ctl;
  mline_t pins_raw, pins_s, line_st, flag_st, wr_flags;

  always_ff @(posedge clk) begin
    if (rst)          ctl <= '0;
    else if (ctrl_wr) ctl <= mctl_t'(ctrl_wdata);
  end

  always_comb begin
    pins_raw.cts = cts_n;
    pins_raw.dsr = dsr_n;
    pins_raw.ri  = ri_n;
    pins_raw.dcd = dcd_n;
  end

  assign wr_flags = mline_t'(stat_wdata);

  modem_sync #(.WIDTH(MLINE_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pins_raw),
    .dout(pins_s)
  );

  modem_status u_status (
    .clk     (clk),
    .rst     (rst),
    .loop_en (ctl.loop),
    .lb_rts  (ctl.rts),
    .lb_dtr  (ctl.dtr),
    .lb_out1 (ctl.out1),
    .lb_out2 (ctl.out2),
    .pins_n  (pins_s),
    .rd_clr  (stat_rd),
    .wr_set  (stat_wr),
    .wr_flags(wr_flags),
    .line_q  (line_st),
    .flag_q  (flag_st),
    .irq_q   (ms_irq)
  );

  modem_flow #(.LVL_W(LVL_W)) u_flow (
    .clk       (clk),
    .rst       (rst),
    .loop_en   (ctl.loop),
    .afc_en    (ctl.afc),
    .rts_bit   (ctl.rts),
    .dtr_bit   (ctl.dtr),
    .out1_bit  (ctl.out1),
    .out2_bit  (ctl.out2),
    .level     (rx_level),
    .trig      (rx_trig),
    .start_seen(rx_start),
    .cts_now   (line_st.cts),
    .rts_n     (rts_n),
    .dtr_n     (dtr_n),
    .out1_n    (out1_n),
    .out2_n    (out2_n),
    .loop_q    (loop_active),
    .permit_q  (tx_permit)
  );

  assign stat_q = {line_st, flag_st};
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       stat_rd,
  input logic [7:0] stat_q,
  input logic       rts_n,
  input logic       dtr_n,
  input logic       out1_n,
  input logic       out2_n,
  input logic       loop_active,
  input logic       tx_permit,
  input logic       ms_irq
);
  AST_RESET_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stat_q == 8'h00 && rts_n && dtr_n && out1_n && out2_n
                    && !loop_active && tx_permit && !ms_irq)); // R1

  AST_LOOP_HANDSHAKE_IDLE: assert property (@(posedge clk) disable iff (rst)
    loop_active |-> (rts_n && dtr_n && out1_n && out2_n)); // R7

  AST_IRQ_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    ms_irq == (stat_q[3:0] != 4'h0)); // R6

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0]))); // R5

  AST_PERMIT_NEEDS_CTS: assert property (@(posedge clk) disable iff (rst)
    !tx_permit |-> !$past(stat_q[4])); // R10
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .stat_rd    (stat_rd),
  .stat_q     (stat_q),
  .rts_n      (rts_n),
  .dtr_n      (dtr_n),
  .out1_n     (out1_n),
  .out2_n     (out2_n),
  .loop_active(loop_active),
  .tx_permit  (tx_permit),
  .ms_irq     (ms_irq)
);

// File: tb/tb_uart_modem_ctl.sv
module tb_uart_modem_ctl;
  localparam int LVL_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_wr = 1'b0;
  logic [5:0] ctrl_wdata = '0;
  logic stat_rd = 1'b0, stat_wr = 1'b0;
  logic [3:0] stat_wdata = '0;
  logic [7:0] stat_q;
  logic [3:0] pins_n = 4'hF; // {dcd_n, ri_n, dsr_n, cts_n}
  logic [LVL_W-1:0] rx_level = '0, rx_trig = 5'd4;
  logic rx_start = 1'b0;
  logic rts_n, dtr_n, out1_n, out2_n, loop_active, tx_permit, ms_irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_modem_ctl #(.LVL_W(LVL_W)) dut (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_q(stat_q),
    .cts_n(pins_n[0]), .dsr_n(pins_n[1]), .ri_n(pins_n[2]), .dcd_n(pins_n[3]),
    .rx_level(rx_level), .rx_trig(rx_trig), .rx_start(rx_start),
    .rts_n(rts_n), .dtr_n(dtr_n), .out1_n(out1_n), .out2_n(out2_n),
    .loop_active(loop_active), .tx_permit(tx_permit), .ms_irq(ms_irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [5:0] v);
    ctrl_wdata = v; ctrl_wr = 1'b1; tick(1); ctrl_wr = 1'b0; tick(6);
  endtask

  task automatic rd_clear();
    stat_rd = 1'b1; tick(1); stat_rd = 1'b0; tick(2);
  endtask

  task automatic wr_flags(input logic [3:0] v);
    stat_wdata = v; stat_wr = 1'b1; tick(1); stat_wr = 1'b0; tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] act_a, act_b, lb, exp_fl;
    logic [9:0] exp_v;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check("R1", {stat_q, rts_n, dtr_n, out1_n, out2_n, loop_active, tx_permit, ms_irq},
          {8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0});

    // Exhaustive control x pin sweep: R2 R3 R7 R10
    for (int c = 0; c < 64; c++) begin
      for (int p = 0; p < 16; p++) begin
        pins_n = p[3:0];
        wr_ctrl(c[5:0]);
        rd_clear();
        lb = {c[3], c[2], c[0], c[1]}; // dcd, ri, dsr, cts
        act_a = c[4] ? lb : ~p[3:0];
        exp_v[9:6] = c[4] ? 4'hF : {~c[1], ~c[0], ~c[2], ~c[3]};
        exp_v[5]   = c[4];
        exp_v[4]   = ~c[5] | act_a[0];
        exp_v[3:0] = act_a;
        check(c[4] ? "R7" : "R2/R3/R10",
              {rts_n, dtr_n, out1_n, out2_n, loop_active, tx_permit, stat_q[7:4]}, exp_v);
        check("R5/R6", {stat_q[3:0], ms_irq}, 5'h0);
      end
    end

    // Pin transition sweep for change flags: R4 R6
    wr_ctrl(6'h00);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        pins_n = a[3:0]; tick(6);
        rd_clear();
        pins_n = b[3:0]; tick(6);
        act_a = ~a[3:0]; act_b = ~b[3:0];
        exp_fl = {act_a[3] ^ act_b[3], ~act_a[2] & act_b[2],
                  act_a[1] ^ act_b[1], act_a[0] ^ act_b[0]};
        check("R4", stat_q[3:0], exp_fl);
        check("R6", ms_irq, |exp_fl);
      end
    end

    // R5: read clears older flag, coincident event survives
    pins_n = 4'hF; tick(6); rd_clear();
    pins_n = 4'hD; tick(6);               // DSR change
    check("R5", stat_q[3:0], 4'b0010);
    pins_n = 4'hC;                        // CTS change
    tick(2); stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
    check("R5", stat_q[3:0], 4'b0001);
    tick(2); rd_clear();
    check("R5", stat_q[3:0], 4'b0000);

    // R8: loopback flag writes
    wr_ctrl(6'h10); rd_clear();
    for (int w = 0; w < 16; w++) begin
      wr_flags(w[3:0]);
      check("R8", stat_q[3:0], w[3:0]);
      wr_flags(4'h0);
      check("R8", stat_q[3:0], w[3:0]);
      rd_clear();
    end
    // R7: pins ignored in loopback
    pins_n = 4'hF; tick(6);
    check("R7", {stat_q[7:4], stat_q[3:0]}, 8'h00);
    wr_ctrl(6'h00); pins_n = 4'hF; tick(6); rd_clear();
    wr_flags(4'hF);
    check("R8", stat_q[3:0], 4'h0);

    // R9: automatic flow control
    rx_trig = 5'd8;
    for (int lvl = 0; lvl < 32; lvl++) begin
      wr_ctrl(6'h22);
      rx_level = lvl[4:0]; tick(2);
      check("R9", rts_n, 1'b0);
      rx_start = 1'b1; tick(1); rx_start = 1'b0; tick(3);
      check("R9", rts_n, lvl >= 8);
      rx_level = 5'd7; tick(3);
      check("R9", rts_n, 1'b0);
    end
    rx_level = 5'd12; wr_ctrl(6'h20);
    rx_start = 1'b1; tick(1); rx_start = 1'b0; tick(3);
    check("R9", rts_n, 1'b1);
    wr_ctrl(6'h02);
    rx_start = 1'b1; tick(1); rx_start = 1'b0; tick(3);
    check("R9", rts_n, 1'b0);

    // R10: permit follows CTS with auto-flow
    wr_ctrl(6'h20); pins_n = 4'hF; tick(6);
    check("R10", tx_permit, 1'b0);
    pins_n = 4'hE; tick(6);
    check("R10", tx_permit, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule